// File: doc/BRIEF.md
# Flow-through synchronous burst SRAM

This block models a single-port synchronous static RAM with a 32-bit word and a flow-through read path. Commands are captured on the rising clock edge while the active-low clock enable is low. A command is an address, a read/write choice and a load/advance choice. A captured read presents the addressed word during the very next clock period, with no output register in the way. A captured write takes its data from the input bus at the following enabled edge. Because of this, a read and a write can follow each other with no idle cycle between them.

A load cycle starts an access only when all three chip selects are active. Otherwise the device goes idle. Advance cycles step a two-bit beat counter through a four-word group. A static mode input picks linear or interleaved ordering. The upper address bits stay fixed, so a burst wraps inside its aligned group of four words. When clock enable is high, the whole state is frozen and the current operation stretches over the stalled cycles.

The data bus is split into an input, an output and a driver enable for the pad. The output enable gates only that driver enable, and it does so combinationally. During a write data cycle the driver enable is forced low. Depth is a parameter, must be a power of two and at least 4, and defaults to 64 words.

Top module: `ft_burst_sram`

## Requirements
- R1: While `cen_n` is high at a rising edge, nothing changes at that edge. The access state and burst position are held, no write is committed, and `dq_o` keeps showing the same word.
- R2: A load cycle (`load_n` low, `cen_n` low) with any chip select inactive (active means `sel_a_n`=0, `sel_b`=1, `sel_c_n`=0) leaves the device idle. The driver enable is then low, and later advance cycles neither write nor drive until the next selected load.
- R3: After a selected load with `we_n` high, in the very next clock period `dq_o` equals the word at the loaded address and `dq_oe` equals the inverse of `oe_n`.
- R4: After a selected load with `we_n` low, the full 32-bit value on `dq_i` at the next enabled edge is stored at the current burst address.
- R5: With `ilv_mode`=0, beat n of a burst addresses the word whose two low address bits are (start + n) mod 4.
- R6: With `ilv_mode`=1, beat n addresses the word whose two low address bits are start XOR n.
- R7: Each enabled advance moves the beat count by one. After four beats it returns to beat 0, and the address bits above bit 1 never change during a burst.
- R8: `oe_n` acts without a clock: when it goes high, `dq_oe` drops in the same cycle, and when it goes low during a read, `dq_oe` rises again.
- R9: During a write data cycle `dq_oe` is low whatever the level of `oe_n`.
- R10: While `rst_n` is low, and after it is released, no access is active and `dq_oe` is low.
- R11: The last write data edge may carry a new load. A read loaded at that same edge to the word just written returns the new data in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the access state |
| cen_n | input | 1 | Active-low clock enable; high stalls the device |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| load_n | input | 1 | Low loads a new command, high advances the burst |
| we_n | input | 1 | Low selects a write on a load cycle |
| ilv_mode | input | 1 | Static burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous active-low output enable |
| addr | input | AW (6) | Word address captured on load cycles |
| dq_i | input | DW (32) | Write data bus |
| dq_o | output | DW (32) | Flow-through read data |
| dq_oe | output | 1 | Driver enable for the data pad |

## Verification
Two things can happen at one enabled edge: the last write data beat is committed, and a new read command is loaded for the same word. The bench ends write bursts with a step that carries both the final data word and a read load of that address. It then compares the word that flows out in the next cycle against a reference array. Random traffic with stalls, partial chip selects and mixed burst orders makes the same overlap happen at random addresses. Every cycle is judged against a bench model of the access state and the memory contents.

// File: rtl/ft_burst_sram.sv
`timescale 1ns/1ps
module ft_burst_sram #(
  parameter int DW = 32,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cen_n,
  input  logic          sel_a_n,
  input  logic          sel_b,
  input  logic          sel_c_n,
  input  logic          load_n,
  input  logic          we_n,
  input  logic          ilv_mode,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe
);

  logic          act;
  logic          wr;
  logic [AW-1:0] base;
  logic [1:0]    beat;
  logic [DW-1:0] mem [DEPTH];

  wire sel_all = ~sel_a_n & sel_b & ~sel_c_n;
  wire step    = ~cen_n;

  wire [1:0]    low = ilv_mode ? (base[1:0] ^ beat) : (base[1:0] + beat);
  wire [AW-1:0] cur = {base[AW-1:2], low};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act  <= 1'b0;
      wr   <= 1'b0;
      base <= '0;
      beat <= '0;
    end else if (step) begin
      if (!load_n) begin
        act  <= sel_all;
        wr   <= sel_all & ~we_n;
        base <= addr;
        beat <= '0;
      end else if (act) begin
        beat <= beat + 2'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (step && act && wr) mem[cur] <= dq_i;
  end

  assign dq_o  = mem[cur];
  assign dq_oe = act & ~wr & ~oe_n;

endmodule

// File: rtl/ft_burst_sram_chk.sv
`timescale 1ns/1ps
module ft_burst_sram_chk #(
  parameter int DW = 32,
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cen_n,
  input logic          sel_a_n,
  input logic          sel_b,
  input logic          sel_c_n,
  input logic          load_n,
  input logic          we_n,
  input logic          oe_n,
  input logic [DW-1:0] dq_o,
  input logic          dq_oe,
  input logic          act,
  input logic [1:0]    beat,
  input logic [AW-1:0] cur
);

  wire sel_all = ~sel_a_n & sel_b & ~sel_c_n;

  assert_stall_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cen_n |=> ($stable(cur) && $stable(dq_o) && $stable(act)));

  assert_deselect_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !load_n && !sel_all) |=> !dq_oe);

  assert_read_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !load_n && sel_all && we_n) |=> (dq_oe == !oe_n));

  assert_beat_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && load_n && act) |=> (beat == $past(beat) + 2'd1));

  assert_oe_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);

  assert_write_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !load_n && sel_all && !we_n) |=> !dq_oe);

endmodule

bind ft_burst_sram ft_burst_sram_chk #(.DW(DW), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
  .sel_c_n(sel_c_n), .load_n(load_n), .we_n(we_n), .oe_n(oe_n), .dq_o(dq_o),
  .dq_oe(dq_oe), .act(act), .beat(beat), .cur(cur)
);

// File: tb/ft_burst_sram_tb_top.sv
`timescale 1ns/1ps
module ft_burst_sram_tb_top;
  localparam int DW = 32;
  localparam int DEPTH = 64;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cen_n = 1'b1, sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
  logic load_n = 1'b1, we_n = 1'b1, ilv_mode = 1'b0, oe_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_i = '0;
  logic [DW-1:0] dq_o;
  logic dq_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit m_act = 1'b0, m_wr = 1'b0;
  logic [AW-1:0] m_base = '0;
  logic [1:0] m_beat = '0;
  logic [DW-1:0] ref_mem [DEPTH];

  always #4 clk = ~clk;

  ft_burst_sram #(.DW(DW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .load_n(load_n), .we_n(we_n), .ilv_mode(ilv_mode),
    .oe_n(oe_n), .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  function automatic logic [AW-1:0] burst_addr(logic [AW-1:0] start, logic [1:0] n, bit ilv);
    logic [1:0] lo;
    lo = ilv ? (start[1:0] ^ n) : (start[1:0] + n);
    return {start[AW-1:2], lo};
  endfunction

  task automatic judge(bit ok, string tag, logic [DW-1:0] act_v, logic [DW-1:0] exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act_v, exp_v);
    end
  endtask

  task automatic step(bit en, bit ld, bit [2:0] sel, bit wr, logic [AW-1:0] a,
                      logic [DW-1:0] d, bit oe, string tag);
    logic [AW-1:0] c;
    bit exp_oe;
    @(negedge clk);
    cen_n = ~en; load_n = ~ld; sel_a_n = ~sel[0]; sel_b = sel[1]; sel_c_n = ~sel[2];
    we_n = ~wr; addr = a; dq_i = d; oe_n = ~oe;
    @(posedge clk);
    if (en) begin
      c = burst_addr(m_base, m_beat, ilv_mode);
      if (m_act && m_wr) ref_mem[c] = d;
      if (ld) begin
        m_act = &sel; m_wr = (&sel) & wr; m_base = a; m_beat = '0;
      end else if (m_act) begin
        m_beat = m_beat + 2'd1;
      end
    end
    #1;
    c = burst_addr(m_base, m_beat, ilv_mode);
    exp_oe = m_act && !m_wr && oe;
    judge(dq_oe === exp_oe, tag, {31'd0, dq_oe}, {31'd0, exp_oe});
    if (exp_oe) judge(dq_o === ref_mem[c], tag, dq_o, ref_mem[c]);
    oe_n = oe;
    #1;
    exp_oe = m_act && !m_wr && !oe;
    judge(dq_oe === exp_oe, (m_act && m_wr) ? "R9" : "R8", {31'd0, dq_oe}, {31'd0, exp_oe});
    oe_n = ~oe;
  endtask

  task automatic wr_burst(logic [AW-1:0] start, int beats, string tag);
    step(1, 1, 3'b111, 1, start, $urandom, 1, tag);
    for (int k = 0; k < beats; k++) step(1, 0, 3'b111, 0, '0, $urandom, 1, tag);
  endtask

  task automatic rd_burst(logic [AW-1:0] start, int beats, string tag);
    step(1, 1, 3'b111, 0, start, $urandom, 1, tag);
    for (int k = 1; k < beats; k++) step(1, 0, 3'b111, 0, '0, $urandom, 1, tag);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    #1;
    judge(dq_oe === 1'b0, "R10", {31'd0, dq_oe}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    step(1, 0, 3'b111, 0, '0, '0, 1, "R10");

    // R4: fill every word, linear bursts
    ilv_mode = 1'b0;
    for (int g = 0; g < DEPTH / 4; g++) wr_burst(AW'(g * 4), 4, "R4");

    // R5 and R7: linear reads from each offset, five beats to show the wrap
    for (int s = 0; s < 4; s++) rd_burst(AW'(20 + s), 5, (s == 1) ? "R7" : "R5");

    // R6: interleaved reads and an interleaved write read back
    ilv_mode = 1'b1;
    for (int s = 0; s < 4; s++) rd_burst(AW'(36 + s), 5, "R6");
    wr_burst(AW'(42), 4, "R6");
    rd_burst(AW'(40), 4, "R6");
    ilv_mode = 1'b0;
    rd_burst(AW'(40), 4, "R6");

    // R11: last write beat and a read load of the same word share an edge
    step(1, 1, 3'b111, 1, AW'(9), '0, 1, "R11");
    step(1, 1, 3'b111, 0, AW'(9), 32'hCAFE_0011, 1, "R11");
    judge(dq_o === 32'hCAFE_0011, "R11", dq_o, 32'hCAFE_0011);

    // R1: stalls inside a read burst and inside a write burst
    step(1, 1, 3'b111, 0, AW'(13), '0, 1, "R1");
    step(0, 0, 3'b111, 0, '0, '0, 1, "R1");
    step(0, 1, 3'b000, 1, AW'(50), '0, 1, "R1");
    step(1, 0, 3'b111, 0, '0, '0, 1, "R1");
    step(1, 1, 3'b111, 1, AW'(24), '0, 1, "R1");
    step(0, 0, 3'b111, 0, '0, 32'hDEAD_0001, 1, "R1");
    step(0, 0, 3'b111, 0, '0, 32'hDEAD_0002, 1, "R1");
    step(1, 0, 3'b111, 0, '0, 32'hBEEF_0003, 1, "R1");
    rd_burst(AW'(24), 2, "R1");
    judge(ref_mem[24] === 32'hBEEF_0003, "R1", ref_mem[24], 32'hBEEF_0003);

    // R2: each partial select on a load leaves the device idle
    for (int p = 0; p < 7; p++) begin
      step(1, 1, 3'(p), 1, AW'(32), '0, 1, "R2");
      step(1, 0, 3'(p), 0, '0, 32'h0BAD_0000, 1, "R2");
      step(1, 0, 3'(p), 0, '0, 32'h0BAD_0001, 1, "R2");
    end
    rd_burst(AW'(32), 2, "R2");

    // R3: random traffic judged against the model
    for (int blk = 0; blk < 4; blk++) begin
      ilv_mode = blk[0];
      for (int i = 0; i < 600; i++) begin
        bit en, ld, wr, oe;
        bit [2:0] sel;
        en  = ($urandom_range(0, 9) < 8);
        ld  = ($urandom_range(0, 9) < 3);
        sel = ($urandom_range(0, 9) < 8) ? 3'b111 : 3'($urandom);
        wr  = $urandom_range(0, 1);
        oe  = ($urandom_range(0, 9) < 8);
        step(en, ld, sel, wr, AW'($urandom), $urandom, oe, "R3");
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule